// File: doc/BRIEF.md
# Timer Compare Match Unit

This block watches a free-running timer count and a programmed compare value. On the cycle where the two first become equal, it carries out the action chosen by a 4-bit mode code. The code can toggle, set or clear an output pin, raise only an interrupt flag, or fire a special event. A special event sends a one-cycle timer-reset pulse and, when the converter is enabled, a one-cycle ADC-start pulse. Every compare action sets a sticky interrupt flag, which software clears through a dedicated clear input.

The timer and the converter live outside the block. The unit reports through `pin_en` whether it currently owns the pin or leaves it to the general-purpose port. Mode code 0000 switches the unit off and returns its state to reset values. All other codes that are not compare codes do nothing.

All outputs except `pin_en` are registered. An action seen at a rising clock edge becomes visible right after that edge.

Top module: `cmu_compare_unit`

## Requirements
- R1: After reset, `pin_out` equals `PIN_RST_VAL` (0 by default), and `irq_flag`, `tmr_rst` and `adc_start` are 0.
- R2: A match is taken only on the first cycle where `tmr_val` equals `cmp_val`. While the two stay equal, no further action follows. A new match needs the values to differ for at least one cycle first.
- R3: With mode 4'b0010, a match inverts `pin_out` and sets `irq_flag`.
- R4: With mode 4'b1000, a match drives `pin_out` to 1. With mode 4'b1001, a match drives it to 0. Both set `irq_flag`.
- R5: With mode 4'b1010, a match sets `irq_flag` and leaves `pin_out` unchanged.
- R6: With mode 4'b1011, a match sets `irq_flag` and leaves `pin_out` unchanged. It raises `tmr_rst` for exactly one cycle. It raises `adc_start` in that same cycle only if `adc_en` is 1.
- R7: With the reserved codes 4'b0001 and 4'b0011, and with any code of the form 01xx or 11xx, a match changes none of the outputs.
- R8: While the mode is 4'b0000, the registered outputs are held at their reset values and the match history is cleared. If the values are already equal when a compare mode is then selected, that counts as a match.
- R9: `irq_flag` stays set until a cycle with `flag_clr` = 1 clears it. If a flag-setting match and `flag_clr` fall in the same cycle, the flag ends up set.
- R10: `pin_en` is 1 exactly when the mode is 4'b0010, 4'b1000 or 4'b1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_val | input | TMR_W | Current timer count |
| cmp_val | input | TMR_W | Compare value |
| mode | input | 4 | Mode code |
| adc_en | input | 1 | Converter enabled; gates `adc_start` |
| flag_clr | input | 1 | Clears `irq_flag` |
| pin_out | output | 1 | Compare pin level |
| pin_en | output | 1 | Unit owns the pin (combinational from `mode`) |
| irq_flag | output | 1 | Sticky match interrupt flag |
| tmr_rst | output | 1 | One-cycle timer reset request |
| adc_start | output | 1 | One-cycle conversion start request |

## Verification
The bench builds the unit with its defaults: a 16-bit timer, one-shot matching and a pin that resets low. The 16-bit width lets directed matches land on the extreme counts 0 and 16'hFFFF, which exercises the full-width comparator. One-shot matching makes the hold-equal case observable: toggle mode keeps the pin steady across several equal cycles. Re-entering from mode 0000 while the values are already equal shows that switching off clears the match history.

// File: rtl/cmu_pkg.sv
package cmu_pkg;

   localparam logic [3:0] CMU_OFF    = 4'b0000;
   localparam logic [3:0] CMU_TOGGLE = 4'b0010;
   localparam logic [3:0] CMU_SET    = 4'b1000;
   localparam logic [3:0] CMU_CLEAR  = 4'b1001;
   localparam logic [3:0] CMU_SWINT  = 4'b1010;
   localparam logic [3:0] CMU_SPEV   = 4'b1011;

   // Decoded action for the current mode code
   typedef struct packed {
      logic off;      // unit disabled, state held at reset
      logic flag;     // match sets the interrupt flag
      logic pin_set;  // match drives pin high
      logic pin_clr;  // match drives pin low
      logic pin_tgl;  // match inverts pin
      logic spev;     // match fires the special event
      logic drive;    // unit owns the pin
   } cmu_act_t;

endpackage

// File: rtl/cmu_mode_dec.sv
module cmu_mode_dec
   import cmu_pkg::*;
(
   input  logic [3:0] mode,
   output cmu_act_t   act
);

   always_comb begin
      act = '0;
      unique case (mode)
         CMU_OFF:    act.off = 1'b1;
         CMU_TOGGLE: begin act.flag = 1'b1; act.pin_tgl = 1'b1; act.drive = 1'b1; end
         CMU_SET:    begin act.flag = 1'b1; act.pin_set = 1'b1; act.drive = 1'b1; end
         CMU_CLEAR:  begin act.flag = 1'b1; act.pin_clr = 1'b1; act.drive = 1'b1; end
         CMU_SWINT:  act.flag = 1'b1;
         CMU_SPEV:   begin act.flag = 1'b1; act.spev = 1'b1; end
         default:    act = '0;   // reserved, capture and PWM codes
      endcase
   end

   // R10
   pin_owner_chk: assert final (act.drive == (act.pin_set | act.pin_clr | act.pin_tgl));

endmodule

// File: rtl/cmu_match_det.sv
module cmu_match_det #(
   parameter int unsigned TMR_W    = 16,
   parameter bit          ONE_SHOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             off,
   input  logic [TMR_W-1:0] tmr_val,
   input  logic [TMR_W-1:0] cmp_val,
   output logic             match
);

   logic eq;
   assign eq = (tmr_val == cmp_val);

   generate
      if (ONE_SHOT) begin : g_edge
         logic eq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   eq_q <= 1'b0;
            else if (off) eq_q <= 1'b0;
            else          eq_q <= eq;
         end
         assign match = eq & ~eq_q;

         // R2
         // match_once_chk
         match_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (match && !off) |=> !match);
      end else begin : g_level
         assign match = eq;
      end
   endgenerate

endmodule

// File: rtl/cmu_act_reg.sv
module cmu_act_reg
   import cmu_pkg::*;
#(
   parameter bit PIN_RST_VAL = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  cmu_act_t act,
   input  logic     match,
   input  logic     adc_en,
   input  logic     flag_clr,
   output logic     pin_out,
   output logic     irq_flag,
   output logic     tmr_rst,
   output logic     adc_start
);

   logic hit;
   assign hit = match & ~act.off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out   <= PIN_RST_VAL;
         irq_flag  <= 1'b0;
         tmr_rst   <= 1'b0;
         adc_start <= 1'b0;
      end else if (act.off) begin
         pin_out   <= PIN_RST_VAL;
         irq_flag  <= 1'b0;
         tmr_rst   <= 1'b0;
         adc_start <= 1'b0;
      end else begin
         tmr_rst   <= hit & act.spev;
         adc_start <= hit & act.spev & adc_en;
         if (hit && act.flag) irq_flag <= 1'b1;
         else if (flag_clr)   irq_flag <= 1'b0;
         if (hit) begin
            if (act.pin_set)      pin_out <= 1'b1;
            else if (act.pin_clr) pin_out <= 1'b0;
            else if (act.pin_tgl) pin_out <= ~pin_out;
         end
      end
   end

   // R6
   // adc_with_reset_chk
   adc_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> tmr_rst);

   // R6
   // tmr_rst_cause_chk
   tmr_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_rst |-> $past(hit && act.spev));

   // R9
   // flag_sticky_chk
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_flag) |-> $past(flag_clr || act.off));

   // R7
   // flag_cause_chk
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(hit && act.flag));

   // R5
   // pin_hold_chk
   pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_out) |-> $past(act.drive || act.off));

endmodule

// File: rtl/cmu_compare_unit.sv
module cmu_compare_unit
   import cmu_pkg::*;
#(
   parameter int unsigned TMR_W       = 16,
   parameter bit          ONE_SHOT    = 1'b1,
   parameter bit          PIN_RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] tmr_val,
   input  logic [TMR_W-1:0] cmp_val,
   input  logic [3:0]       mode,
   input  logic             adc_en,
   input  logic             flag_clr,
   output logic             pin_out,
   output logic             pin_en,
   output logic             irq_flag,
   output logic             tmr_rst,
   output logic             adc_start
);

   generate
      if (TMR_W < 2 || TMR_W > 64) begin : g_bad_width
         $error("cmu_compare_unit: TMR_W must lie in 2..64");
      end
   endgenerate

   cmu_act_t act;
   logic     match;

   cmu_mode_dec u_dec (
      .mode (mode),
      .act  (act)
   );

   cmu_match_det #(
      .TMR_W    (TMR_W),
      .ONE_SHOT (ONE_SHOT)
   ) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .off     (act.off),
      .tmr_val (tmr_val),
      .cmp_val (cmp_val),
      .match   (match)
   );

   cmu_act_reg #(
      .PIN_RST_VAL (PIN_RST_VAL)
   ) u_act (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act),
      .match     (match),
      .adc_en    (adc_en),
      .flag_clr  (flag_clr),
      .pin_out   (pin_out),
      .irq_flag  (irq_flag),
      .tmr_rst   (tmr_rst),
      .adc_start (adc_start)
   );

   assign pin_en = act.drive;

   // R8
   // off_state_chk
   off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode == CMU_OFF) |-> (!irq_flag && !tmr_rst && !adc_start && pin_out == PIN_RST_VAL));

endmodule

// File: tb/cmu_compare_unit_bench.sv
module cmu_compare_unit_bench;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] tmr_val = '0;
   logic [W-1:0] cmp_val = 16'd1000;
   logic [3:0]   mode = 4'b0000;
   logic         adc_en = 1'b0;
   logic         flag_clr = 1'b0;
   logic         pin_out, pin_en, irq_flag, tmr_rst, adc_start;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   cmu_compare_unit u_cmu_compare_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .tmr_val   (tmr_val),
      .cmp_val   (cmp_val),
      .mode      (mode),
      .adc_en    (adc_en),
      .flag_clr  (flag_clr),
      .pin_out   (pin_out),
      .pin_en    (pin_en),
      .irq_flag  (irq_flag),
      .tmr_rst   (tmr_rst),
      .adc_start (adc_start)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Move away from the compare value, then land on it; outputs sampled after the edge
   task automatic hit(input logic [W-1:0] c);
      cmp_val = c;
      tmr_val = c - 1'b1;
      tick();
      tmr_val = c;
      tick();
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      tick();
      flag_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "pin_out", pin_out, 1'b0);
      chk("R1", "irq_flag", irq_flag, 1'b0);
      chk("R1", "tmr_rst", tmr_rst, 1'b0);
      chk("R1", "adc_start", adc_start, 1'b0);
   endtask

   task automatic t_toggle();
      mode = 4'b0010;
      tick();
      chk("R10", "pin_en toggle", pin_en, 1'b1);
      hit(16'd1000);
      chk("R3", "pin after toggle", pin_out, 1'b1);
      chk("R3", "flag after toggle", irq_flag, 1'b1);
      for (int i = 0; i < 3; i++) tick();
      chk("R2", "pin held while equal", pin_out, 1'b1);
      hit(16'hFFFF);
      chk("R3", "second toggle at max", pin_out, 1'b0);
      tmr_val = 16'hFFFF;
      cmp_val = 16'h0000;
      tick();
      tmr_val = 16'h0000;
      tick();
      chk("R3", "toggle at zero", pin_out, 1'b1);
   endtask

   task automatic t_set_clear();
      clear_flag();
      chk("R9", "flag cleared", irq_flag, 1'b0);
      mode = 4'b1001;
      hit(16'd500);
      chk("R4", "clear mode pin", pin_out, 1'b0);
      chk("R4", "clear mode flag", irq_flag, 1'b1);
      mode = 4'b1000;
      hit(16'd700);
      chk("R4", "set mode pin", pin_out, 1'b1);
      hit(16'd900);
      chk("R4", "set mode pin stays", pin_out, 1'b1);
   endtask

   task automatic t_swint();
      clear_flag();
      mode = 4'b1010;
      tick();
      chk("R10", "pin_en swint", pin_en, 1'b0);
      hit(16'd42);
      chk("R5", "swint flag", irq_flag, 1'b1);
      chk("R5", "swint pin unchanged", pin_out, 1'b1);
   endtask

   task automatic t_special();
      clear_flag();
      mode = 4'b1011;
      adc_en = 1'b0;
      hit(16'd300);
      chk("R6", "tmr_rst pulse", tmr_rst, 1'b1);
      chk("R6", "adc_start gated", adc_start, 1'b0);
      chk("R6", "special flag", irq_flag, 1'b1);
      chk("R6", "special pin unchanged", pin_out, 1'b1);
      tick();
      chk("R6", "tmr_rst one cycle", tmr_rst, 1'b0);
      adc_en = 1'b1;
      hit(16'd301);
      chk("R6", "tmr_rst with adc", tmr_rst, 1'b1);
      chk("R6", "adc_start pulse", adc_start, 1'b1);
      tick();
      chk("R6", "adc_start one cycle", adc_start, 1'b0);
      adc_en = 1'b0;
   endtask

   task automatic t_reserved();
      logic [3:0] codes [4] = '{4'b0001, 4'b0011, 4'b0101, 4'b1110};
      for (int k = 0; k < 4; k++) begin
         clear_flag();
         mode = codes[k];
         tick();
         chk("R10", "pin_en reserved", pin_en, 1'b0);
         hit(16'd77 + 16'(k));
         chk("R7", "reserved flag", irq_flag, 1'b0);
         chk("R7", "reserved pin", pin_out, 1'b1);
         chk("R7", "reserved tmr_rst", tmr_rst, 1'b0);
      end
   endtask

   task automatic t_flag();
      mode = 4'b1010;
      hit(16'd60);
      chk("R9", "flag set", irq_flag, 1'b1);
      for (int i = 0; i < 4; i++) tick();
      chk("R9", "flag sticky", irq_flag, 1'b1);
      clear_flag();
      chk("R9", "flag cleared by clr", irq_flag, 1'b0);
      cmp_val = 16'd61;
      tmr_val = 16'd60;
      tick();
      tmr_val = 16'd61;
      flag_clr = 1'b1;
      tick();
      flag_clr = 1'b0;
      chk("R9", "set wins over clr", irq_flag, 1'b1);
   endtask

   task automatic t_off();
      mode = 4'b0000;
      tick();
      chk("R8", "off pin", pin_out, 1'b0);
      chk("R8", "off flag", irq_flag, 1'b0);
      chk("R10", "pin_en off", pin_en, 1'b0);
      cmp_val = 16'd5;
      tmr_val = 16'd5;
      tick();
      tick();
      mode = 4'b1000;
      tick();
      chk("R8", "match on re-entry", pin_out, 1'b1);
      chk("R8", "flag on re-entry", irq_flag, 1'b1);
   endtask

   initial begin
      fork
         begin
            repeat (3) tick();
            rst_n = 1'b1;
            tick();
            t_reset();
            t_toggle();
            t_set_clear();
            t_swint();
            t_special();
            t_reserved();
            t_flag();
            t_off();
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule